// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Router

This block sits behind a 32-line GPIO bank and turns its input activity into interrupt requests for one, two or four processors. The bank supplies a data vector that has already been corrected for polarity, plus one edge-detect pulse per line. The router keeps a sticky edge cause per processor (or one shared cause), an edge mask and a level mask per processor. From these it forms a pending word for each processor and reduces it to one request per group of eight lines.

Software reaches the registers over a simple register bus. A window select picks either the main register window or a dedicated per-processor window. A parameter fixes the register layout. In the four-processor layout every processor has a private cause copy in the per-processor window, so each processor acknowledges and masks its own interrupts without disturbing the others. In the two-processor layout the masks are duplicated in the main window and the cause is shared. The one-processor layout has a single set of three registers.

Top module: `gpio_cpu_irq_router`

## Requirements
- R1: After reset every cause register and every mask register reads zero and every interrupt output is low.
- R2: LAYOUT=2 gives four processors. In the per-processor window (busSel=1), processor n has its edge cause at byte offset n*4, its edge mask at 0x10+n*4 and its level mask at 0x20+n*4.
- R3: LAYOUT=1 gives two processors in the main window (busSel=0): a shared edge cause at 0x14, processor 0 masks at 0x18 (edge) and 0x1C (level), and processor 1 masks at 0x30 (edge) and 0x34 (level). LAYOUT=0 gives one processor with its cause at 0x14, edge mask at 0x18 and level mask at 0x1C in the main window.
- R4: An edge pulse on line i sets bit i in every cause copy at the next clock edge, and the bit stays set until software clears it.
- R5: A write of word W to a cause register clears the bits where W is 0 and keeps the bits where W is 1. In the four-processor layout only the addressed processor's copy changes.
- R6: When an edge pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Interrupt output irqOut[n*4+g] is the OR, over lines 8g to 8g+7, of (dataIn AND level mask n) OR (cause of n AND edge mask n). It follows register state in the same cycle, with no extra latency.
- R8: Level-masked lines act on the current dataIn only. When the input drops, the request drops, and the cause registers do not change.
- R9: An access to an offset the active layout does not map reads as zero, and a write to it changes no register. This covers the other window, misaligned offsets and processor indices past the count.
- R10: A write to a mask register replaces all 32 bits, and a read returns the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | NUM_LINES | Polarity-corrected line levels from the bank |
| edgePulse | input | NUM_LINES | One-cycle edge-detect pulses from the bank |
| busSel | input | 1 | Window select: 0 main window, 1 per-processor window |
| busAddr | input | ADDR_W | Byte offset within the selected window |
| busWrEn | input | 1 | Write strobe, taken at the clock edge |
| busWrData | input | NUM_LINES | Write data |
| busRdData | output | NUM_LINES | Read data for busSel/busAddr, combinational |
| irqOut | output | NUM_CPUS*NUM_LINES/GROUP_W | Grouped requests, processor-major |

## Verification
The bench builds three copies of the router that share the same line inputs. The copies use LAYOUT=2, LAYOUT=1 and LAYOUT=0, each with 32 lines, groups of eight and an 8-bit offset. This brings every address map within reach, and the effect of one edge pulse can be compared across a private cause per processor, a shared cause and a single cause. The four-processor copy is checked against a model of masks and causes kept in the bench. That copy is used to show that one processor's acknowledgement leaves the other copies untouched, and it covers the collision between an edge pulse and a clear.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

  localparam int MAX_CPUS = 4;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_CAUSE = 2'd1,
    KIND_EDGE  = 2'd2,
    KIND_LEVEL = 2'd3
  } regKind_e;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic [MAX_CPUS-1:0] causeWr;
    logic [MAX_CPUS-1:0] edgeWr;
    logic [MAX_CPUS-1:0] levelWr;
    regKind_e            rdKind;
    logic [1:0]          rdIdx;
  } regStrobe_t;

  // 0: one processor, 1: two processors, 2: four processors
  function automatic int cpusFor(input int layout);
    return (layout == 2) ? 4 : ((layout == 1) ? 2 : 1);
  endfunction

  function automatic int causeCopiesFor(input int layout);
    return (layout == 2) ? 4 : 1;
  endfunction

endpackage

// File: rtl/gpio_route_ctrl.sv
module gpio_route_ctrl
  import gpio_route_pkg::*;
#(
  parameter int LAYOUT = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        stb
);

  localparam int NUM_CPUS = cpusFor(LAYOUT);

  localparam logic [ADDR_W-1:0] OFF_CAUSE  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_EDGE0  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFF_LEVEL0 = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFF_EDGE1  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFF_LEVEL1 = ADDR_W'(8'h34);

  regKind_e   hitKind;
  logic [1:0] hitIdx;

  generate
    if (LAYOUT == 2) begin : g_quad
      // Per-processor window: [5:4] picks the register kind, [3:2] the processor
      always_comb begin
        hitKind = KIND_NONE;
        hitIdx  = 2'd0;
        if (busSel && (busAddr[1:0] == 2'b00) && (busAddr[ADDR_W-1:6] == '0)) begin
          hitIdx = busAddr[3:2];
          case (busAddr[5:4])
            2'd0:    hitKind = KIND_CAUSE;
            2'd1:    hitKind = KIND_EDGE;
            2'd2:    hitKind = KIND_LEVEL;
            default: hitKind = KIND_NONE;
          endcase
        end
      end
    end else if (LAYOUT == 1) begin : g_dual
      always_comb begin
        hitKind = KIND_NONE;
        hitIdx  = 2'd0;
        if (!busSel) begin
          case (busAddr)
            OFF_CAUSE:  hitKind = KIND_CAUSE;
            OFF_EDGE0:  hitKind = KIND_EDGE;
            OFF_LEVEL0: hitKind = KIND_LEVEL;
            OFF_EDGE1:  begin hitKind = KIND_EDGE;  hitIdx = 2'd1; end
            OFF_LEVEL1: begin hitKind = KIND_LEVEL; hitIdx = 2'd1; end
            default:    hitKind = KIND_NONE;
          endcase
        end
      end
    end else begin : g_single
      always_comb begin
        hitKind = KIND_NONE;
        hitIdx  = 2'd0;
        if (!busSel) begin
          case (busAddr)
            OFF_CAUSE:  hitKind = KIND_CAUSE;
            OFF_EDGE0:  hitKind = KIND_EDGE;
            OFF_LEVEL0: hitKind = KIND_LEVEL;
            default:    hitKind = KIND_NONE;
          endcase
        end
      end
    end
  endgenerate

  always_comb begin
    stb        = '0;
    stb.rdKind = hitKind;
    stb.rdIdx  = hitIdx;
    if (busWrEn) begin
      case (hitKind)
        KIND_CAUSE: stb.causeWr[hitIdx] = 1'b1;
        KIND_EDGE:  stb.edgeWr[hitIdx]  = 1'b1;
        KIND_LEVEL: stb.levelWr[hitIdx] = 1'b1;
        default:    ;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.causeWr, stb.edgeWr, stb.levelWr})); // R2

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdKind != KIND_NONE) |-> (int'(stb.rdIdx) < NUM_CPUS)); // R9

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> ({stb.causeWr, stb.edgeWr, stb.levelWr} == '0)); // R9

endmodule

// File: rtl/gpio_route_datapath.sv
module gpio_route_datapath
  import gpio_route_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int GROUP_W   = 8,
  parameter int NUM_CPUS  = 4,
  parameter int NUM_CAUSE = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  regStrobe_t                        stb,
  input  logic [NUM_LINES-1:0]              busWrData,
  input  logic [NUM_LINES-1:0]              dataIn,
  input  logic [NUM_LINES-1:0]              edgePulse,
  output logic [NUM_LINES-1:0]              busRdData,
  output logic [NUM_CPUS*(NUM_LINES/GROUP_W)-1:0] irqOut
);

  localparam int NUM_GROUPS = NUM_LINES / GROUP_W;

  logic [NUM_LINES-1:0] causeQ     [NUM_CAUSE];
  logic [NUM_LINES-1:0] edgeMaskQ  [NUM_CPUS];
  logic [NUM_LINES-1:0] levelMaskQ [NUM_CPUS];
  logic [NUM_LINES-1:0] pendVec    [NUM_CPUS];

  genvar c, n, g;

  // Cause copies: edge pulses set bits, a write keeps only the bits written as one
  generate
    for (c = 0; c < NUM_CAUSE; c++) begin : g_cause
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                causeQ[c] <= '0;
        else if (stb.causeWr[c])  causeQ[c] <= (causeQ[c] & busWrData) | edgePulse;
        else                      causeQ[c] <= causeQ[c] | edgePulse;
      end

      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (|edgePulse) |=> ((causeQ[c] & $past(edgePulse)) == $past(edgePulse))); // R4

      AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (!stb.causeWr[c] && (edgePulse == '0)) |=> $stable(causeQ[c])); // R5

      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
        stb.causeWr[c] |=> ((causeQ[c] & ~($past(busWrData) | $past(edgePulse))) == '0)); // R5
    end

    for (n = 0; n < NUM_CPUS; n++) begin : g_cpu
      localparam int CI = (NUM_CAUSE == 1) ? 0 : n;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          edgeMaskQ[n]  <= '0;
          levelMaskQ[n] <= '0;
        end else begin
          if (stb.edgeWr[n])  edgeMaskQ[n]  <= busWrData;
          if (stb.levelWr[n]) levelMaskQ[n] <= busWrData;
        end
      end

      assign pendVec[n] = (dataIn & levelMaskQ[n]) | (causeQ[CI] & edgeMaskQ[n]);

      for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign irqOut[n*NUM_GROUPS+g] = |pendVec[n][g*GROUP_W +: GROUP_W];
      end

      AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !stb.edgeWr[n] |=> $stable(edgeMaskQ[n])); // R10

      AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
        ((edgeMaskQ[n] == '0) && (levelMaskQ[n] == '0))
          |-> (irqOut[n*NUM_GROUPS +: NUM_GROUPS] == '0)); // R7
    end
  endgenerate

  // Read-back multiplexer, selected by the decoder
  always_comb begin
    busRdData = '0;
    case (stb.rdKind)
      KIND_CAUSE: begin
        for (int k = 0; k < NUM_CAUSE; k++)
          if (stb.rdIdx == 2'(k)) busRdData = causeQ[k];
      end
      KIND_EDGE: begin
        for (int k = 0; k < NUM_CPUS; k++)
          if (stb.rdIdx == 2'(k)) busRdData = edgeMaskQ[k];
      end
      KIND_LEVEL: begin
        for (int k = 0; k < NUM_CPUS; k++)
          if (stb.rdIdx == 2'(k)) busRdData = levelMaskQ[k];
      end
      default: busRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_cpu_irq_router.sv
module gpio_cpu_irq_router
  import gpio_route_pkg::*;
#(
  parameter int LAYOUT    = 2,
  parameter int NUM_LINES = 32,
  parameter int GROUP_W   = 8,
  parameter int ADDR_W    = 8,
  localparam int NUM_CPUS   = cpusFor(LAYOUT),
  localparam int NUM_CAUSE  = causeCopiesFor(LAYOUT),
  localparam int NUM_GROUPS = NUM_LINES / GROUP_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_LINES-1:0]           dataIn,
  input  logic [NUM_LINES-1:0]           edgePulse,
  input  logic                           busSel,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWrEn,
  input  logic [NUM_LINES-1:0]           busWrData,
  output logic [NUM_LINES-1:0]           busRdData,
  output logic [NUM_CPUS*NUM_GROUPS-1:0] irqOut
);

  regStrobe_t stb;

  gpio_route_ctrl #(
    .LAYOUT (LAYOUT),
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  gpio_route_datapath #(
    .NUM_LINES (NUM_LINES),
    .GROUP_W   (GROUP_W),
    .NUM_CPUS  (NUM_CPUS),
    .NUM_CAUSE (NUM_CAUSE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWrData (busWrData),
    .dataIn    (dataIn),
    .edgePulse (edgePulse),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/gpio_cpu_irq_router_tb_top.sv
module gpio_cpu_irq_router_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [31:0] dataIn, edgePulse, busWrData;
  logic        busSel;
  logic [7:0]  busAddr;
  logic        wrQ, wrD, wrS;
  logic [31:0] rdQ, rdD, rdS;
  logic [15:0] irqQ;
  logic [7:0]  irqD;
  logic [3:0]  irqS;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mCause [4];
  logic [31:0] mEdge  [4];
  logic [31:0] mLevel [4];

  gpio_cpu_irq_router #(.LAYOUT(2)) dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .edgePulse(edgePulse), .busSel(busSel),
    .busAddr(busAddr), .busWrEn(wrQ), .busWrData(busWrData), .busRdData(rdQ), .irqOut(irqQ));

  gpio_cpu_irq_router #(.LAYOUT(1)) dutDual_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .edgePulse(edgePulse), .busSel(busSel),
    .busAddr(busAddr), .busWrEn(wrD), .busWrData(busWrData), .busRdData(rdD), .irqOut(irqD));

  gpio_cpu_irq_router #(.LAYOUT(0)) dutSingle_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .edgePulse(edgePulse), .busSel(busSel),
    .busAddr(busAddr), .busWrEn(wrS), .busWrData(busWrData), .busRdData(rdS), .irqOut(irqS));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expIrqQ();
    logic [15:0] e = '0;
    for (int n = 0; n < 4; n++) begin
      logic [31:0] p = (dataIn & mLevel[n]) | (mCause[n] & mEdge[n]);
      for (int g = 0; g < 4; g++) e[n*4+g] = |p[g*8 +: 8];
    end
    return e;
  endfunction

  // which: 2 quad, 1 dual, 0 single
  task automatic wr(input int which, input logic sel, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = sel; busAddr = a; busWrData = d;
    wrQ = (which == 2); wrD = (which == 1); wrS = (which == 0);
    @(negedge clk);
    wrQ = 1'b0; wrD = 1'b0; wrS = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] a);
    @(negedge clk);
    busSel = sel; busAddr = a;
    #1;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); edgePulse = v;
    @(negedge clk); edgePulse = '0;
    for (int n = 0; n < 4; n++) mCause[n] = mCause[n] | v;
  endtask

  task automatic qEdge(input int n, input logic [31:0] d);
    wr(2, 1'b1, 8'(8'h10 + n*4), d); mEdge[n] = d;
  endtask

  task automatic qLevel(input int n, input logic [31:0] d);
    wr(2, 1'b1, 8'(8'h20 + n*4), d); mLevel[n] = d;
  endtask

  task automatic qClr(input int n, input logic [31:0] d);
    wr(2, 1'b1, 8'(n*4), d); mCause[n] = mCause[n] & d;
  endtask

  task automatic readAllQuad(input string req);
    for (int n = 0; n < 4; n++) begin
      rd(1'b1, 8'(n*4));          check(req, rdQ, mCause[n]);
      rd(1'b1, 8'(8'h10 + n*4));  check(req, rdQ, mEdge[n]);
      rd(1'b1, 8'(8'h20 + n*4));  check(req, rdQ, mLevel[n]);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 quad irq", 32'(irqQ), 32'h0);
    check("R1 dual irq", 32'(irqD), 32'h0);
    check("R1 single irq", 32'(irqS), 32'h0);
    readAllQuad("R1 quad regs");
    rd(1'b0, 8'h14); check("R1 dual cause", rdD, 32'h0); check("R1 single cause", rdS, 32'h0);
    rd(1'b0, 8'h30); check("R1 dual edge1", rdD, 32'h0);
  endtask

  task automatic t_quadMap();
    for (int n = 0; n < 4; n++) begin
      qEdge(n, 32'h0000_0101 << n);
      qLevel(n, 32'h0100_0000 << (2*n));
    end
    readAllQuad("R2 R10 quad map");
    check("R7 quad idle", 32'(irqQ), 32'(expIrqQ()));
  endtask

  task automatic t_edgeSet();
    pulse(32'h0000_0101);
    #1;
    check("R7 after edge", 32'(irqQ), 32'(expIrqQ()));
    check("R7 cpu0 groups", 32'(irqQ[3:0]), 32'h3);
    repeat (3) @(negedge clk);
    for (int n = 0; n < 4; n++) begin
      rd(1'b1, 8'(n*4)); check("R4 sticky cause", rdQ, 32'h0000_0101);
    end
  endtask

  task automatic t_localClear();
    qClr(1, 32'hFFFF_FFFE);
    rd(1'b1, 8'h04); check("R5 cleared copy", rdQ, 32'h0000_0100);
    rd(1'b1, 8'h00); check("R5 other copy 0", rdQ, 32'h0000_0101);
    rd(1'b1, 8'h08); check("R5 other copy 2", rdQ, 32'h0000_0101);
    rd(1'b1, 8'h0C); check("R5 other copy 3", rdQ, 32'h0000_0101);
    check("R7 after clear", 32'(irqQ), 32'(expIrqQ()));
  endtask

  task automatic t_collision();
    @(negedge clk);
    busSel = 1'b1; busAddr = 8'h00; busWrData = 32'h0; wrQ = 1'b1;
    edgePulse = 32'h8000_0000;
    @(negedge clk);
    wrQ = 1'b0; edgePulse = '0;
    mCause[0] = 32'h8000_0000;
    for (int n = 1; n < 4; n++) mCause[n] = mCause[n] | 32'h8000_0000;
    rd(1'b1, 8'h00); check("R6 set wins", rdQ, 32'h8000_0000);
    rd(1'b1, 8'h0C); check("R6 other copy", rdQ, 32'h8000_0101);
  endtask

  task automatic t_pending();
    qEdge(3, 32'h8000_0000);
    #1;
    check("R7 cpu3 group3", 32'(irqQ[15]), 32'h1);
    check("R7 full vector", 32'(irqQ), 32'(expIrqQ()));
  endtask

  task automatic t_level();
    qLevel(2, 32'h00FF_0000);
    @(negedge clk); dataIn = 32'h0001_0000; #1;
    check("R8 level high", 32'(irqQ[10]), 32'h1);
    check("R7 level vector", 32'(irqQ), 32'(expIrqQ()));
    @(negedge clk); dataIn = '0; #1;
    check("R8 level drop", 32'(irqQ[10]), 32'h0);
    rd(1'b1, 8'h08); check("R8 cause untouched", rdQ, mCause[2]);
  endtask

  task automatic t_unmapped();
    wr(2, 1'b0, 8'h14, 32'hFFFF_FFFF);
    wr(2, 1'b1, 8'h12, 32'hFFFF_FFFF);
    wr(2, 1'b1, 8'h40, 32'h0);
    rd(1'b0, 8'h14); check("R9 main window", rdQ, 32'h0);
    rd(1'b1, 8'h30); check("R9 offset 0x30", rdQ, 32'h0);
    rd(1'b1, 8'h02); check("R9 misaligned", rdQ, 32'h0);
    readAllQuad("R9 no write effect");
  endtask

  task automatic t_dual();
    wr(1, 1'b0, 8'h14, 32'h0);
    wr(1, 1'b0, 8'h18, 32'h0000_00FF);
    wr(1, 1'b0, 8'h30, 32'h0000_FF00);
    wr(1, 1'b0, 8'h1C, 32'h0);
    wr(1, 1'b0, 8'h34, 32'h0);
    rd(1'b0, 8'h18); check("R3 dual edge0", rdD, 32'h0000_00FF);
    rd(1'b0, 8'h30); check("R3 dual edge1", rdD, 32'h0000_FF00);
    rd(1'b0, 8'h14); check("R3 dual cause", rdD, 32'h0);
    pulse(32'h0000_0100);
    rd(1'b0, 8'h14); check("R4 dual shared cause", rdD, 32'h0000_0100);
    check("R3 dual irq cpu1", 32'(irqD), 32'h0000_0020);
    wr(1, 1'b0, 8'h14, 32'hFFFF_FEFF);
    #1;
    check("R5 dual cleared", 32'(irqD), 32'h0);
    rd(1'b1, 8'h04); check("R9 dual other window", rdD, 32'h0);
  endtask

  task automatic t_single();
    wr(0, 1'b0, 8'h14, 32'h0);
    wr(0, 1'b0, 8'h18, 32'h0F00_0000);
    wr(0, 1'b0, 8'h1C, 32'h0000_0002);
    rd(1'b0, 8'h18); check("R3 single edge", rdS, 32'h0F00_0000);
    rd(1'b0, 8'h1C); check("R3 single level", rdS, 32'h0000_0002);
    @(negedge clk); dataIn = 32'h0000_0002; #1;
    check("R7 single level irq", 32'(irqS), 32'h1);
    @(negedge clk); dataIn = '0;
    pulse(32'h0100_0000);
    #1;
    check("R7 single edge irq", 32'(irqS), 32'h8);
    rd(1'b0, 8'h14); check("R4 single cause", rdS, 32'h0100_0000);
    rd(1'b0, 8'h30); check("R9 single 0x30", rdS, 32'h0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; dataIn = '0; edgePulse = '0; busWrData = '0;
    busSel = 1'b0; busAddr = '0; wrQ = 1'b0; wrD = 1'b0; wrS = 1'b0;
    for (int n = 0; n < 4; n++) begin mCause[n] = '0; mEdge[n] = '0; mLevel[n] = '0; end
    t_reset();
    t_quadMap();
    t_edgeSet();
    t_localClear();
    t_collision();
    t_pending();
    t_level();
    t_unmapped();
    t_dual();
    t_single();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finishRun();
  end

endmodule